// File: doc/BRIEF.md
# Two-Wire Bus Event Decoder

The block listens to the clock and data lines of a two-wire serial bus and never drives them. Both lines are sampled by a fast system clock through synchronisers. The block turns the line activity into a stream of tagged events: bus start, repeated start, stop, a complete address with its direction flag, data byte, acknowledge and missing acknowledge. Each event appears for a single system clock cycle on a valid strobe. A type code and a payload travel with it.

The block holds its own record of whether the bus is taken. This lets it tell a fresh start from a repeated one. It rebuilds a 10-bit address from the two bytes that carry it and then reports it as one event. A start or stop that arrives in the middle of a byte throws away the partial byte. Typical uses are a trigger engine, a trace recorder or a protocol checker that sits beside the bus.

Top module: `i2c_evt_mon`

## Requirements
- R1: SDA falling while SCL is high, with the bus free (after reset or after a stop), produces event type 0 (start) with payload 0.
- R2: SDA falling while SCL is high, with no stop since the previous start, produces event type 1 (repeated start) with payload 0.
- R3: SDA rising while SCL is high produces event type 2 (stop) with payload 0, and the bus becomes free.
- R4: Bits are taken on SCL rising edges, most significant bit first. The first byte after any start is the address byte. If its top five bits are not 11110, the block emits event type 3 (address) after the eighth bit. The payload holds the upper seven bits of the byte in payload[6:0], the rw flag is bit 0 of the byte, and the ten flag is 0.
- R5: If the first byte after a start begins with 11110, the block emits no address event for it. Its bits [2:1] become address bits [9:8] and its bit 0 becomes the rw flag. The following byte gives address bits [7:0]. After that byte, the block emits one type 3 event with the 10-bit address and the ten flag set to 1.
- R6: Every later byte until the next start or stop produces event type 4 (data), with the byte in payload[7:0] and payload[9:8] equal to 0.
- R7: The ninth SCL rising edge after each byte (address bytes included) produces event type 5 (acknowledge) if SDA is low, or type 6 (missing acknowledge) if SDA is high, with payload 0.
- R8: A start or stop in the middle of a byte drops the partial bits without any data event. The bit count restarts, so the next byte is framed from its first bit.
- R9: SCL and SDA activity with the bus free, other than a start condition, produces no event.
- R10: The rw and ten flags are 0 on every event other than type 3.
- R11: During and after reset, the strobe is low and the bus counts as free, so the first start after reset is reported as type 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| evt_v_o | output | 1 | One-cycle event strobe |
| evt_type_o | output | 3 | Event code: 0 start, 1 repeated start, 2 stop, 3 address, 4 data, 5 ack, 6 missing ack |
| evt_payload_o | output | ADDR_W (10) | Address (type 3) or data byte (type 4); 0 otherwise |
| evt_rw_o | output | 1 | Direction bit of an address event, 1 for read |
| evt_ten_o | output | 1 | Set on an address event built from two bytes |

## Verification
A wrong bus-taken flag shows up at the next start condition as the wrong one of codes 0 and 1. A slipped bit counter shows up on the next byte boundary as a shifted payload, or as an acknowledge event in place of a data event. A wrong phase shows up as a data event where an address event was due, or as a 10-bit address assembled from the wrong bytes. Each of these faults reaches the ports within one byte time of the condition that exposes it. The bench compares the whole ordered event list of every transfer, so a missing or extra event is caught as well as a wrong value.

// File: rtl/i2c_evt_pkg.sv
package i2c_evt_pkg;

  typedef enum logic [2:0] {
    EV_START  = 3'd0,
    EV_RSTART = 3'd1,
    EV_STOP   = 3'd2,
    EV_ADDR   = 3'd3,
    EV_DATA   = 3'd4,
    EV_ACK    = 3'd5,
    EV_NACK   = 3'd6
  } evt_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ADDR_LO,
    PH_DATA
  } phase_e;

  localparam logic [4:0] TEN_PREFIX = 5'b11110;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic prev_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // idle bus level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign q_o    = chain_q[STAGES-1];
  assign prev_o = prev_q;

endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic scl_q_i,
  input  logic scl_p_i,
  input  logic sda_q_i,
  input  logic sda_p_i,
  output logic start_o,
  output logic stop_o,
  output logic rise_o
);

  logic scl_hold;

  assign scl_hold = scl_q_i & scl_p_i;
  assign start_o  = scl_hold & sda_p_i & ~sda_q_i;
  assign stop_o   = scl_hold & ~sda_p_i & sda_q_i;
  assign rise_o   = scl_q_i & ~scl_p_i;

endmodule

// File: rtl/i2c_bit_framer.sv
module i2c_bit_framer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              active_i,
  input  logic              rise_i,
  input  logic              sda_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              ack_done_o,
  output logic              nak_o
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] shreg_q;
  logic              take;

  assign take        = active_i & rise_i;
  assign byte_done_o = take & (cnt_q == CNT_W'(BYTE_W - 1));
  assign byte_o      = {shreg_q, sda_i};
  assign ack_done_o  = take & (cnt_q == CNT_W'(BYTE_W));
  assign nak_o       = sda_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      shreg_q <= '0;
    end else if (clear_i) begin
      cnt_q   <= '0;
    end else if (take) begin
      if (cnt_q == CNT_W'(BYTE_W)) begin
        cnt_q <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        shreg_q <= {shreg_q[BYTE_W-3:0], sda_i};
      end
    end
  end

endmodule

// File: rtl/i2c_evt_track.sv
module i2c_evt_track
  import i2c_evt_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_done_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              ack_done_i,
  input  logic              nak_i,
  output logic              busy_o,
  output logic              evt_v_o,
  output evt_e              evt_type_o,
  output logic [ADDR_W-1:0] payload_o,
  output logic              rw_o,
  output logic              ten_o
);

  localparam int HI_W = ADDR_W - BYTE_W;

  phase_e            phase_q, phase_d;
  logic              busy_q, busy_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic              rw_q, rw_d;

  logic              ev_v;
  evt_e              ev_t;
  logic [ADDR_W-1:0] ev_p;
  logic              ev_rw, ev_ten;

  always_comb begin
    phase_d = phase_q;
    busy_d  = busy_q;
    hi_d    = hi_q;
    rw_d    = rw_q;
    ev_v    = 1'b0;
    ev_t    = EV_START;
    ev_p    = '0;
    ev_rw   = 1'b0;
    ev_ten  = 1'b0;
    if (start_i) begin
      ev_v    = 1'b1;
      ev_t    = busy_q ? EV_RSTART : EV_START;
      busy_d  = 1'b1;
      phase_d = PH_ADDR;
    end else if (stop_i) begin
      ev_v    = 1'b1;
      ev_t    = EV_STOP;
      busy_d  = 1'b0;
      phase_d = PH_IDLE;
    end else if (byte_done_i) begin
      unique case (phase_q)
        PH_ADDR: begin
          if (byte_i[BYTE_W-1 -: 5] == TEN_PREFIX) begin
            hi_d    = byte_i[HI_W:1];
            rw_d    = byte_i[0];
            phase_d = PH_ADDR_LO;
          end else begin
            ev_v    = 1'b1;
            ev_t    = EV_ADDR;
            ev_p    = ADDR_W'(byte_i[BYTE_W-1:1]);
            ev_rw   = byte_i[0];
            phase_d = PH_DATA;
          end
        end
        PH_ADDR_LO: begin
          ev_v    = 1'b1;
          ev_t    = EV_ADDR;
          ev_p    = {hi_q, byte_i};
          ev_rw   = rw_q;
          ev_ten  = 1'b1;
          phase_d = PH_DATA;
        end
        PH_DATA: begin
          ev_v = 1'b1;
          ev_t = EV_DATA;
          ev_p = ADDR_W'(byte_i);
        end
        default: ;
      endcase
    end else if (ack_done_i) begin
      ev_v = 1'b1;
      ev_t = nak_i ? EV_NACK : EV_ACK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      busy_q     <= 1'b0;
      hi_q       <= '0;
      rw_q       <= 1'b0;
      evt_v_o    <= 1'b0;
      evt_type_o <= EV_START;
      payload_o  <= '0;
      rw_o       <= 1'b0;
      ten_o      <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      busy_q     <= busy_d;
      hi_q       <= hi_d;
      rw_q       <= rw_d;
      evt_v_o    <= ev_v;
      evt_type_o <= ev_t;
      payload_o  <= ev_p;
      rw_o       <= ev_rw;
      ten_o      <= ev_ten;
    end
  end

  assign busy_o = busy_q;

endmodule

// File: rtl/i2c_evt_mon.sv
module i2c_evt_mon
  import i2c_evt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 10,
  parameter int BYTE_W      = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              evt_v_o,
  output logic [2:0]        evt_type_o,
  output logic [ADDR_W-1:0] evt_payload_o,
  output logic              evt_rw_o,
  output logic              evt_ten_o
);

  localparam int N_LINES = 2;

  logic [N_LINES-1:0] line_raw, line_q, line_p;
  logic start, stop, rise;
  logic byte_done, ack_done, nak, busy;
  logic [BYTE_W-1:0] byte_val;
  evt_e evt_type;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (line_raw[g]),
      .q_o    (line_q[g]),
      .prev_o (line_p[g])
    );
  end

  i2c_cond_det u_cond (
    .scl_q_i (line_q[0]),
    .scl_p_i (line_p[0]),
    .sda_q_i (line_q[1]),
    .sda_p_i (line_p[1]),
    .start_o (start),
    .stop_o  (stop),
    .rise_o  (rise)
  );

  i2c_bit_framer #(.BYTE_W(BYTE_W)) u_framer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (start | stop),
    .active_i    (busy),
    .rise_i      (rise),
    .sda_i       (line_q[1]),
    .byte_done_o (byte_done),
    .byte_o      (byte_val),
    .ack_done_o  (ack_done),
    .nak_o       (nak)
  );

  i2c_evt_track #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .stop_i      (stop),
    .byte_done_i (byte_done),
    .byte_i      (byte_val),
    .ack_done_i  (ack_done),
    .nak_i       (nak),
    .busy_o      (busy),
    .evt_v_o     (evt_v_o),
    .evt_type_o  (evt_type),
    .payload_o   (evt_payload_o),
    .rw_o        (evt_rw_o),
    .ten_o       (evt_ten_o)
  );

  assign evt_type_o = evt_type;

endmodule

// File: rtl/i2c_evt_mon_chk.sv
module i2c_evt_mon_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              evt_v_o,
  input logic [2:0]        evt_type_o,
  input logic [ADDR_W-1:0] evt_payload_o,
  input logic              evt_rw_o,
  input logic              evt_ten_o
);

  localparam logic [2:0] T_START = 3'd0, T_RSTART = 3'd1, T_STOP = 3'd2,
                         T_ADDR = 3'd3, T_DATA = 3'd4, T_ACK = 3'd5, T_NACK = 3'd6;

  logic busy_m;
  logic is_sta;

  assign is_sta = evt_v_o && (evt_type_o == T_START || evt_type_o == T_RSTART);

  // bus-taken state rebuilt from the event stream only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                busy_m <= 1'b0;
    else if (is_sta)                            busy_m <= 1'b1;
    else if (evt_v_o && evt_type_o == T_STOP)   busy_m <= 1'b0;
  end

  p_fresh_start_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sta && !busy_m |-> evt_type_o == T_START);

  p_restart_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_sta && busy_m |-> evt_type_o == T_RSTART);

  p_idle_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_v_o && !busy_m |-> (evt_type_o == T_START || evt_type_o == T_STOP));

  p_flags_addr_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_v_o && evt_type_o != T_ADDR |-> !evt_rw_o && !evt_ten_o);

  p_payload_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_v_o && (evt_type_o == T_START || evt_type_o == T_RSTART || evt_type_o == T_STOP ||
                evt_type_o == T_ACK || evt_type_o == T_NACK) |-> evt_payload_o == '0);

  p_data_width_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_v_o && evt_type_o == T_DATA |-> (evt_payload_o >> 8) == '0);

  p_short_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_v_o && evt_type_o == T_ADDR && !evt_ten_o |-> (evt_payload_o >> 7) == '0);

  p_legal_type_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_v_o |-> evt_type_o <= T_NACK);

endmodule

bind i2c_evt_mon i2c_evt_mon_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .evt_v_o       (evt_v_o),
  .evt_type_o    (evt_type_o),
  .evt_payload_o (evt_payload_o),
  .evt_rw_o      (evt_rw_o),
  .evt_ten_o     (evt_ten_o)
);

// File: tb/i2c_evt_mon_bench.sv
module i2c_evt_mon_bench;
  import i2c_evt_pkg::*;

  localparam int H = 8;
  localparam int NV = 6;
  // {ten, addr[9:0], rw, data[7:0], nak_addr, nak_data}
  localparam logic [21:0] VECS [0:NV-1] = '{
    {1'b0, 10'h050, 1'b0, 8'hA5, 1'b0, 1'b0},
    {1'b0, 10'h07F, 1'b1, 8'h3C, 1'b0, 1'b1},
    {1'b0, 10'h000, 1'b0, 8'h00, 1'b1, 1'b0},
    {1'b0, 10'h02A, 1'b1, 8'hFF, 1'b0, 1'b0},
    {1'b1, 10'h2C5, 1'b0, 8'h96, 1'b0, 1'b0},
    {1'b1, 10'h1FF, 1'b1, 8'h01, 1'b1, 1'b1}
  };

  logic clk_i = 1'b0;
  logic rst_ni;
  logic scl_i, sda_i;
  logic evt_v_o, evt_rw_o, evt_ten_o;
  logic [2:0] evt_type_o;
  logic [9:0] evt_payload_o;

  int total = 0, bad = 0;
  int ev_n = 0, rd = 0;
  bit done = 0;
  logic [2:0] ev_t [0:63];
  logic [9:0] ev_p [0:63];
  logic       ev_rw [0:63];
  logic       ev_ten [0:63];

  always #2 clk_i = ~clk_i;

  i2c_evt_mon u_i2c_evt_mon (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_i(sda_i),
    .evt_v_o(evt_v_o), .evt_type_o(evt_type_o), .evt_payload_o(evt_payload_o),
    .evt_rw_o(evt_rw_o), .evt_ten_o(evt_ten_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni === 1'b1 && evt_v_o === 1'b1 && ev_n < 64) begin
      ev_t[ev_n]   = evt_type_o;
      ev_p[ev_n]   = evt_payload_o;
      ev_rw[ev_n]  = evt_rw_o;
      ev_ten[ev_n] = evt_ten_o;
      ev_n++;
    end
  end

  task automatic hold();
    repeat (H) @(negedge clk_i);
  endtask

  task automatic clear_log();
    ev_n = 0;
    rd   = 0;
  endtask

  task automatic do_start();
    sda_i = 1'b1; hold();
    scl_i = 1'b1; hold();
    sda_i = 1'b0; hold();
    scl_i = 1'b0; hold();
  endtask

  task automatic do_stop();
    sda_i = 1'b0; hold();
    scl_i = 1'b1; hold();
    sda_i = 1'b1; hold();
    hold();
  endtask

  task automatic send_bit(input logic b);
    sda_i = b;    hold();
    scl_i = 1'b1; hold();
    scl_i = 1'b0; hold();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic nak);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    send_bit(nak);
  endtask

  task automatic expect_ev(input logic [2:0] t, input logic [9:0] p, input logic rw,
                           input logic ten, input string req);
    total++;
    if (rd >= ev_n) begin
      bad++;
      $display("FAIL %s: event %0d missing, got %0d events, expected type=%0d payload=%h",
               req, rd, ev_n, t, p);
    end else if (ev_t[rd] !== t || ev_p[rd] !== p || ev_rw[rd] !== rw || ev_ten[rd] !== ten) begin
      bad++;
      $display("FAIL %s: event %0d type=%0d payload=%h rw=%b ten=%b expected type=%0d payload=%h rw=%b ten=%b",
               req, rd, ev_t[rd], ev_p[rd], ev_rw[rd], ev_ten[rd], t, p, rw, ten);
    end
    rd++;
  endtask

  task automatic expect_end(input string req);
    total++;
    if (ev_n != rd) begin
      bad++;
      $display("FAIL %s: event count %0d expected %0d", req, ev_n, rd);
    end
  endtask

  function automatic logic [2:0] ack_code(input logic nak);
    return nak ? EV_NACK : EV_ACK;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; scl_i = 1'b1; sda_i = 1'b1;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    hold();
    // R11: quiet after reset
    total++;
    if (evt_v_o !== 1'b0 || ev_n != 0) begin
      bad++;
      $display("FAIL R11: strobe=%b events=%0d expected strobe=0 events=0", evt_v_o, ev_n);
    end

    // table of transfers
    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      logic ten, rw, nak_a, nak_d;
      logic [9:0] addr;
      logic [7:0] data;
      v = VECS[i];
      ten = v[21]; addr = v[20:11]; rw = v[10]; data = v[9:2]; nak_a = v[1]; nak_d = v[0];
      clear_log();
      do_start();
      if (ten) begin
        send_byte({5'b11110, addr[9:8], rw}, nak_a);
        send_byte(addr[7:0], nak_a);
      end else begin
        send_byte({addr[6:0], rw}, nak_a);
      end
      send_byte(data, nak_d);
      do_stop();
      expect_ev(EV_START, '0, 1'b0, 1'b0, "R1");
      if (ten) begin
        expect_ev(ack_code(nak_a), '0, 1'b0, 1'b0, "R7");
        expect_ev(EV_ADDR, addr, rw, 1'b1, "R5");
      end else begin
        expect_ev(EV_ADDR, addr, rw, 1'b0, "R4");
      end
      expect_ev(ack_code(nak_a), '0, 1'b0, 1'b0, "R7");
      expect_ev(EV_DATA, {2'b00, data}, 1'b0, 1'b0, "R6");
      expect_ev(ack_code(nak_d), '0, 1'b0, 1'b0, "R7");
      expect_ev(EV_STOP, '0, 1'b0, 1'b0, "R3");
      expect_end("R10");
    end

    // R9: clocking on a free bus
    clear_log();
    scl_i = 1'b0; hold();
    send_byte(8'h6D, 1'b1);
    scl_i = 1'b1; hold(); hold();
    expect_end("R9");

    // R8: stop cuts a byte short
    clear_log();
    do_start();
    send_byte(8'hA0, 1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    do_stop();
    expect_ev(EV_START, '0, 1'b0, 1'b0, "R1");
    expect_ev(EV_ADDR, 10'h050, 1'b0, 1'b0, "R4");
    expect_ev(EV_ACK, '0, 1'b0, 1'b0, "R7");
    expect_ev(EV_STOP, '0, 1'b0, 1'b0, "R8");
    expect_end("R8");

    // R2 and R8: repeated start cuts a byte short
    clear_log();
    do_start();
    send_byte({7'h12, 1'b0}, 1'b0);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    do_start();
    send_byte({7'h33, 1'b1}, 1'b0);
    send_byte(8'h5A, 1'b1);
    do_stop();
    expect_ev(EV_START, '0, 1'b0, 1'b0, "R1");
    expect_ev(EV_ADDR, 10'h012, 1'b0, 1'b0, "R4");
    expect_ev(EV_ACK, '0, 1'b0, 1'b0, "R7");
    expect_ev(EV_RSTART, '0, 1'b0, 1'b0, "R2");
    expect_ev(EV_ADDR, 10'h033, 1'b1, 1'b0, "R8");
    expect_ev(EV_ACK, '0, 1'b0, 1'b0, "R7");
    expect_ev(EV_DATA, 10'h05A, 1'b0, 1'b0, "R6");
    expect_ev(EV_NACK, '0, 1'b0, 1'b0, "R7");
    expect_ev(EV_STOP, '0, 1'b0, 1'b0, "R3");
    expect_end("R8");

    // R11: reset mid-transfer leaves the bus free
    clear_log();
    do_start();
    send_byte(8'hA0, 1'b0);
    rst_ni = 1'b0; hold();
    rst_ni = 1'b1; hold();
    total++;
    if (evt_v_o !== 1'b0) begin
      bad++;
      $display("FAIL R11: strobe=%b expected 0 after reset", evt_v_o);
    end
    clear_log();
    do_start();
    send_byte(8'hA1, 1'b0);
    do_stop();
    expect_ev(EV_START, '0, 1'b0, 1'b0, "R11");
    expect_ev(EV_ADDR, 10'h050, 1'b1, 1'b0, "R4");
    expect_ev(EV_ACK, '0, 1'b0, 1'b0, "R7");
    expect_ev(EV_STOP, '0, 1'b0, 1'b0, "R3");
    expect_end("R11");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule